// File: doc/BRIEF.md
# Dual-Strobe Burst SRAM Cycle Controller

This block is the synchronous control path of a common-I/O burst SRAM that has two address strobes: one driven by a processor and one driven by a cache controller. On every rising clock edge it samples three chip enables, both strobes, the advance input and the write controls (a global write, a byte-write enable and one active-low select per byte lane). From these it decides what kind of cycle this is. A cycle can start a burst, continue it, suspend it, deselect the device or do nothing. It also decides whether the cycle reads or writes.

A two-bit burst counter holds the low address bits inside an aligned group of four words. The counter steps in linear or interleaved order. The block writes a small internal array lane by lane. Each lane holds eight data bits plus one parity bit. Reads are flow-through: the array is read with no extra register from the address captured at the last edge. The data is placed on the read bus only while the asynchronous output enable is low and the last cycle was a selected read. Three-state pads are modelled by the flag `rdata_oe_o`. While that flag is low, `rdata_o` is held at zero.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A strobe cycle selects the device only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0 at the clock edge. Otherwise the cycle is a deselect: nothing is written and `rdata_oe_o` is 0 after the edge.
- R2: While `ce1_ni`=1, a low `adsp_ni` is ignored. A cycle with `adsc_ni`=1 then acts as continue or suspend of the running burst, and `addr_i` is not loaded.
- R3: When both strobes are low in the same cycle, only the processor strobe acts, so the cycle is a read that begins a burst.
- R4: A burst begun by the processor strobe is a read. The write controls have no effect in that cycle.
- R5: A selected controller-strobe cycle (`adsp_ni`=1) loads `addr_i` and, if the write controls request it, writes `wdata_i` to that address at the same edge.
- R6: `gw_ni`=0 writes all four lanes, whatever `bwe_ni` and `bw_ni` are.
- R7: With `gw_ni`=1 and `bwe_ni`=0, `bw_ni[k]`=0 writes lane k. Lane k is data bits [8k+7:8k] together with parity bit 32+k of the 36-bit word. Lanes whose select is 1 keep their old contents.
- R8: With `gw_ni`=1 and `bwe_ni`=1, or with `bwe_ni`=0 and all `bw_ni` high, the cycle is a read.
- R9: With no strobe active and `adv_ni`=0, the burst moves to its next address. Step s from the start low bits b gives low bits (b+s) mod 4 when `burst_mode_i`=0 (linear), and b XOR s when `burst_mode_i`=1 (interleaved). The upper address bits stay fixed.
- R10: With no strobe active and `adv_ni`=1, the current burst address is used again.
- R11: After any edge that writes at least one lane, `rdata_oe_o` is 0, even when `oe_ni`=0.
- R12: After a selected read edge, `rdata_o` shows the array word at the address used in that cycle. It is driven, and `rdata_oe_o`=1, exactly while `oe_ni`=0; this follows `oe_ni` with no clock. After reset, `rdata_oe_o`=0 and the array holds zero.
- R13: After a deselect, continue and suspend cycles write nothing and drive nothing until a strobe selects the device again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_ni | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | 4 | Per-lane byte selects, active low |
| burst_mode_i | input | 1 | 1 interleaved order, 0 linear order |
| addr_i | input | 4 | Word address |
| wdata_i | input | 36 | Write data: bytes in [31:0], parity in [35:32] |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Read bus drive flag (models three-state) |

## Verification
Writes land in the array at the very edge that samples the controls. Read data and its drive flag are due in the same cycle, right after the edge that registered the read address, with no added latency. The bench therefore samples 1 ns after each rising edge and compares against a behavioural model that is stepped once per edge. Output-enable gating has no clock, so it is checked in the middle of a cycle by toggling `oe_ni` between edges. Write results are confirmed only by a later read burst, which compares against data patterns computed in the bench.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN,
    CYC_CONT,
    CYC_SUSP
  } cyc_e;
endpackage

// File: rtl/bsram_cycle_decode.sv
module bsram_cycle_decode
  import bsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             active_i,
  output cyc_e             kind_o,
  output logic [LANES-1:0] lane_we_o,
  output logic             is_write_o
);
  logic             sel;
  logic             proc_go;
  logic             ctrl_go;
  logic [LANES-1:0] lane_req;

  assign sel     = ~ce1_ni & ce2_i & ~ce3_ni;
  // processor strobe is masked by ce1; it also wins over the controller strobe
  assign proc_go = ~adsp_ni & ~ce1_ni;
  assign ctrl_go = ~adsc_ni & ~proc_go;

  always_comb begin
    if (!gw_ni)       lane_req = '1;
    else if (!bwe_ni) lane_req = ~bw_ni;
    else              lane_req = '0;
  end

  always_comb begin
    if (proc_go || ctrl_go) kind_o = sel ? CYC_BEGIN : CYC_DESEL;
    else if (active_i)      kind_o = adv_ni ? CYC_SUSP : CYC_CONT;
    else                    kind_o = CYC_IDLE;
  end

  always_comb begin
    unique case (kind_o)
      CYC_BEGIN:          lane_we_o = ctrl_go ? lane_req : '0;
      CYC_CONT, CYC_SUSP: lane_we_o = lane_req;
      default:            lane_we_o = '0;
    endcase
  end

  assign is_write_o = |lane_we_o;
endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr
  import bsram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNT_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_e          kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic          interleave_i,
  output logic [AW-1:0] eff_addr_o,
  output logic [AW-1:0] cur_addr_o
);
  localparam int HI_W = AW - CNT_W;

  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] step_nx;

  function automatic logic [CNT_W-1:0] order_low(input logic [CNT_W-1:0] b,
                                                 input logic [CNT_W-1:0] s,
                                                 input logic intl);
    return intl ? (b ^ s) : (b + s);
  endfunction

  assign step_nx    = step_q + 1'b1;
  assign cur_addr_o = {hi_q, order_low(base_q, step_q, interleave_i)};

  always_comb begin
    unique case (kind_i)
      CYC_BEGIN: eff_addr_o = addr_i;
      CYC_CONT:  eff_addr_o = {hi_q, order_low(base_q, step_nx, interleave_i)};
      default:   eff_addr_o = cur_addr_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      base_q <= '0;
      step_q <= '0;
    end else if (kind_i == CYC_BEGIN) begin
      hi_q   <= addr_i[AW-1:CNT_W];
      base_q <= addr_i[CNT_W-1:0];
      step_q <= '0;
    end else if (kind_i == CYC_CONT) begin
      step_q <= step_nx;
    end
  end
endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = LANES * (BYTE_W + 1),
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int PAR_LSB = LANES * BYTE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BYTE_W:0] mem_q [DEPTH];
    logic [BYTE_W:0] wr_word;
    logic [BYTE_W:0] rd_word;

    assign wr_word = {wdata_i[PAR_LSB+k], wdata_i[k*BYTE_W +: BYTE_W]};
    assign rd_word = mem_q[raddr_i];
    assign rdata_o[k*BYTE_W +: BYTE_W] = rd_word[BYTE_W-1:0];
    assign rdata_o[PAR_LSB+k]          = rd_word[BYTE_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i[k]) begin
        mem_q[waddr_i] <= wr_word;
      end
    end
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2,
  localparam int DW    = LANES * (BYTE_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             burst_mode_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             oe_ni,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_oe_o
);
  cyc_e             kind;
  logic [LANES-1:0] lane_we;
  logic             is_write;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    arr_rdata;
  logic             active_q;
  logic             rd_q;
  logic             in_burst;

  bsram_cycle_decode #(.LANES(LANES)) u_dec (
    .ce1_ni     (ce1_ni),
    .ce2_i      (ce2_i),
    .ce3_ni     (ce3_ni),
    .adsp_ni    (adsp_ni),
    .adsc_ni    (adsc_ni),
    .adv_ni     (adv_ni),
    .gw_ni      (gw_ni),
    .bwe_ni     (bwe_ni),
    .bw_ni      (bw_ni),
    .active_i   (active_q),
    .kind_o     (kind),
    .lane_we_o  (lane_we),
    .is_write_o (is_write)
  );

  bsram_burst_addr #(.AW(AW), .CNT_W(CNT_W)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kind_i       (kind),
    .addr_i       (addr_i),
    .interleave_i (burst_mode_i),
    .eff_addr_o   (eff_addr),
    .cur_addr_o   (cur_addr)
  );

  bsram_lane_array #(.AW(AW), .LANES(LANES), .BYTE_W(BYTE_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .waddr_i (eff_addr),
    .we_i    (lane_we),
    .wdata_i (wdata_i),
    .raddr_i (cur_addr),
    .rdata_o (arr_rdata)
  );

  assign in_burst = (kind == CYC_BEGIN) || (kind == CYC_CONT) || (kind == CYC_SUSP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      if (kind == CYC_BEGIN)      active_q <= 1'b1;
      else if (kind == CYC_DESEL) active_q <= 1'b0;
      rd_q <= in_burst & ~is_write;
    end
  end

  // flow-through: array read from the registered address, gated by async oe
  assign rdata_oe_o = rd_q & ~oe_ni;
  assign rdata_o    = rdata_oe_o ? arr_rdata : '0;
endmodule

// File: rtl/bsram_ctrl_chk.sv
module bsram_ctrl_chk #(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce1_ni,
  input logic             ce2_i,
  input logic             ce3_ni,
  input logic             adsp_ni,
  input logic             adsc_ni,
  input logic             adv_ni,
  input logic             gw_ni,
  input logic             bwe_ni,
  input logic             oe_ni,
  input logic             rdata_oe_o,
  input logic [LANES-1:0] lane_we_i,
  input logic [AW-1:0]    cur_addr_i,
  input logic             active_i
);
  logic sel, pgo, strobe;
  assign sel    = !ce1_ni && ce2_i && !ce3_ni;
  assign pgo    = !adsp_ni && !ce1_ni;
  assign strobe = pgo || !adsc_ni;

  a_r1_desel_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && !sel |-> lane_we_i == '0);
  a_r1_desel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && !sel |=> !rdata_oe_o);
  a_r4_proc_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgo && sel |-> lane_we_i == '0);
  a_r6_global_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel && !pgo && !adsc_ni && !gw_ni |-> lane_we_i == '1);
  a_r8_no_write_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gw_ni && bwe_ni |-> lane_we_i == '0);
  a_r10_suspend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe && adv_ni |=> $stable(cur_addr_i));
  a_r11_write_hides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_we_i != '0 |=> !rdata_oe_o);
  a_r12_oe_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rdata_oe_o);
  a_r13_idle_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe && !active_i |-> lane_we_i == '0);
endmodule

bind burst_sram_ctrl bsram_ctrl_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce1_ni     (ce1_ni),
  .ce2_i      (ce2_i),
  .ce3_ni     (ce3_ni),
  .adsp_ni    (adsp_ni),
  .adsc_ni    (adsc_ni),
  .adv_ni     (adv_ni),
  .gw_ni      (gw_ni),
  .bwe_ni     (bwe_ni),
  .oe_ni      (oe_ni),
  .rdata_oe_o (rdata_oe_o),
  .lane_we_i  (lane_we),
  .cur_addr_i (cur_addr),
  .active_i   (active_q)
);

// File: tb/sim_burst_sram_ctrl.sv
`timescale 1ns/1ps
module sim_burst_sram_ctrl;
  localparam int AW = 4;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, mode, oe_n;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  always #2 clk = ~clk;

  burst_sram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n), .gw_ni(gw_n),
    .bwe_ni(bwe_n), .bw_ni(bw_n), .burst_mode_i(mode), .addr_i(addr),
    .wdata_i(wdata), .oe_ni(oe_n), .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  logic [DW-1:0] mm [16];
  bit m_act = 0, m_rd = 0;
  int m_hi = 0, m_base = 0, m_step = 0, m_addr = 0;

  function automatic logic [DW-1:0] pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {4'(i + 5), b ^ 8'h3C, b + 8'h40, ~b, b * 8'd7};
  endfunction

  function automatic int low_of(input int b, input int s, input bit intl);
    return intl ? ((b ^ s) & 3) : ((b + s) & 3);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] a, input logic [DW-1:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, a, e);
    end
  endtask

  task automatic model_edge();
    bit sel, pv, cv, strobe;
    int be;
    bit wr;
    sel = !ce1_n && ce2 && !ce3_n;
    pv = !adsp_n && !ce1_n;
    cv = !adsc_n && !pv;
    strobe = pv || cv;
    if (!gw_n) be = 15; else if (!bwe_n) be = int'(~bw_n) & 15; else be = 0;
    wr = 0;
    if (strobe) begin
      if (sel) begin
        m_act = 1; m_hi = int'(addr) >> 2; m_base = int'(addr) & 3; m_step = 0;
        if (!cv) be = 0;
      end else begin
        m_act = 0; be = 0;
      end
    end else if (m_act) begin
      if (!adv_n) m_step = (m_step + 1) & 3;
    end else be = 0;
    if (m_act && (strobe ? sel : 1'b1)) begin
      m_addr = m_hi * 4 + low_of(m_base, m_step, mode);
      for (int k = 0; k < 4; k++)
        if (be[k]) begin
          mm[m_addr][k*8 +: 8] = wdata[k*8 +: 8];
          mm[m_addr][32+k]     = wdata[32+k];
          wr = 1;
        end
      m_rd = !wr;
    end else m_rd = 0;
  endtask

  task automatic compare(input string req);
    bit e_oe;
    e_oe = m_rd && !oe_n;
    chk(req, DW'(rdata_oe), DW'(e_oe));
    chk(req, rdata, e_oe ? mm[m_addr] : '0);
  endtask

  // one clock: inputs already set; sample 1 ns after the edge
  task automatic cyc(input string req);
    @(posedge clk);
    model_edge();
    #1;
    compare(req);
    @(negedge clk);
  endtask

  task automatic quiet();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; addr = '0; wdata = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mm[i] = '0;
    quiet(); mode = 0; oe_n = 0;
    #5;
    chk("R12 reset", DW'(rdata_oe), '0);
    chk("R12 reset", rdata, '0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R5 R6 R9: controller-strobe global writes, linear continue fill
    for (int g = 0; g < 4; g++) begin
      quiet(); adsc_n = 0; gw_n = 0; bwe_n = 0; bw_n = 4'hF; addr = AW'(g * 4); wdata = pat(g * 4);
      cyc("R5");
      chk("R11 write hides", DW'(rdata_oe), '0);
      for (int j = 1; j < 4; j++) begin
        quiet(); adv_n = 0; gw_n = 0; wdata = pat(g * 4 + j);
        cyc("R6");
      end
    end

    // R3 R4: both strobes, write controls asserted -> read only
    quiet(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 4'd5; wdata = '1;
    cyc("R3");
    chk("R4 read data", rdata, pat(5));
    chk("R3 driven", DW'(rdata_oe), DW'(1));

    // R12: output enable has no clock
    oe_n = 1; #0.5;
    chk("R12 oe high", DW'(rdata_oe), '0);
    chk("R12 oe high", rdata, '0);
    oe_n = 0; #0.5;
    chk("R12 oe low", rdata, pat(5));

    // R9 linear from 6 -> 6 7 4 5
    quiet(); adsp_n = 0; addr = 4'd6; cyc("R9");
    chk("R9 lin0", rdata, pat(6));
    quiet(); adv_n = 0; cyc("R9"); chk("R9 lin1", rdata, pat(7));
    cyc("R9"); chk("R9 lin2", rdata, pat(4));
    cyc("R9"); chk("R9 lin3", rdata, pat(5));

    // R9 interleaved from 9 -> 9 8 11 10
    mode = 1;
    quiet(); adsp_n = 0; addr = 4'd9; cyc("R9");
    chk("R9 il0", rdata, pat(9));
    quiet(); adv_n = 0; cyc("R9"); chk("R9 il1", rdata, pat(8));
    cyc("R9"); chk("R9 il2", rdata, pat(11));
    cyc("R9"); chk("R9 il3", rdata, pat(10));
    mode = 0;

    // R10 suspend holds address
    quiet(); adsp_n = 0; addr = 4'd10; cyc("R10");
    quiet(); adv_n = 1; cyc("R10"); chk("R10 hold", rdata, pat(10));
    cyc("R10"); chk("R10 hold", rdata, pat(10));

    // R2: processor strobe with ce1 high is ignored; burst continues
    quiet(); adsp_n = 0; addr = 4'd12; cyc("R2");
    quiet(); ce1_n = 1; adsp_n = 0; adv_n = 0; addr = 4'd0; cyc("R2");
    chk("R2 continue", rdata, pat(13));

    // R1 R13: deselect by ce2, then continue/suspend writes ignored
    quiet(); adsc_n = 0; ce2 = 0; gw_n = 0; addr = 4'd2; wdata = '0; cyc("R1");
    chk("R1 quiet", DW'(rdata_oe), '0);
    quiet(); adv_n = 0; gw_n = 0; wdata = '0; cyc("R13");
    chk("R13 no drive", DW'(rdata_oe), '0);
    quiet(); adv_n = 1; gw_n = 0; wdata = '0; cyc("R13");
    quiet(); adsp_n = 0; ce3_n = 1; addr = 4'd2; cyc("R1");
    chk("R1 ce3 quiet", DW'(rdata_oe), '0);
    quiet(); adsp_n = 0; addr = 4'd2; cyc("R13");
    chk("R13 intact", rdata, pat(2));
    quiet(); adv_n = 0; cyc("R13"); chk("R13 intact", rdata, pat(3));

    // R11: write with oe low, also on suspend write
    quiet(); adsc_n = 0; gw_n = 0; addr = 4'd15; wdata = pat(15); cyc("R11");
    chk("R11 adsc write", DW'(rdata_oe), '0);
    quiet(); adv_n = 1; gw_n = 0; wdata = pat(15); cyc("R11");
    chk("R11 suspend write", DW'(rdata_oe), '0);

    // R8: controller strobe with no write request reads
    quiet(); adsc_n = 0; addr = 4'd7; wdata = '1; cyc("R8");
    chk("R8 read", rdata, pat(7));
    quiet(); adsc_n = 0; bwe_n = 0; bw_n = 4'hF; addr = 4'd7; wdata = '1; cyc("R8");
    chk("R8 no lanes", rdata, pat(7));

    // R7: lanes 0 and 2 only
    quiet(); adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = 4'd3; wdata = '1; cyc("R7");
    quiet(); adsp_n = 0; addr = 4'd3; cyc("R7");
    chk("R7 merge", rdata, pat(3) | 36'h5_00FF_00FF);
    // R7 continue byte write lane 3 at 0 via burst from 3 (linear: 3 -> 0)
    quiet(); adv_n = 0; bwe_n = 0; bw_n = 4'b0111; wdata = '0; cyc("R7");
    quiet(); adsp_n = 0; addr = 4'd0; cyc("R7");
    chk("R7 lane3", rdata, pat(0) & 36'h7_00FF_FFFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule